// File: doc/BRIEF.md
# Fuse-Gated Programming Access Controller

This block holds a small bank of active-low configuration fuses. From those fuses it decides which of four programming and debug paths may act on the device: the serial in-system programming port, the JTAG port, the one-wire debug port that shares the reset pin, and a high-voltage programming path. It also rules on every fuse write command. A write command names a source port, a fuse index and a value. Each port has its own rights, so a fuse that JTAG may change can be closed to the serial port. One combination of fuses written through JTAG shuts the device off until the high-voltage path clears it.

A fuse reads 1 when it is unprogrammed, which means inactive. It reads 0 when it is programmed, which usually means active. The erased state of the bank is all ones. An accepted write lands on the clock edge that follows the command. A rejected write leaves the bank alone and raises a one-cycle error pulse. The port enables and the lock flag are decoded combinationally from the registered fuse state and the reset-pin level.

Fuse indices: 0 is the serial-enable fuse, 1 is the reset-pin-disable fuse, 2 is the JTAG-enable fuse and 3 is the one-wire-debug-enable fuse. Source codes: 0 is serial, 1 is JTAG, 2 is one-wire debug and 3 is high-voltage.

Top module: `fuse_access_ctrl`

## Requirements
- R1: While rstN is low, and in the cycle after it rises, all four fuses read 1. `locked`, `wrErr`, `serEn`, `jtagEn` and `wireEn` read 0.
- R2: An accepted write sets fuse `wrIdx` to `wrVal` on the next rising clock edge and leaves the other fuses unchanged. With `wrValid` low, no fuse changes.
- R3: `serEn` is 1 exactly when all of these hold: the device is not locked, `resetHeld` is 1, fuse 0 is 0, fuse 1 is 1 and fuse 3 is 1. Programming fuse 3 to 0 therefore disables serial programming.
- R4: `jtagEn` is 1 exactly when the device is not locked and fuse 2 is 0. `wireEn` is 1 exactly when the device is not locked and fuse 3 is 0.
- R5: A write from source 0 to fuse 0 is always rejected, and fuse 0 keeps its value.
- R6: A write from source 0 is accepted only while `serEn` is 1. Otherwise it is rejected.
- R7: A write from source 1 is accepted only while `jtagEn` is 1, and it may then write any fuse, fuse 0 included.
- R8: When an accepted source-1 write leaves fuses 0 and 2 both at 1, `locked` rises on the same edge. While `locked` is 1, every enable reads 0 and every write from sources 0, 1 and 2 is rejected.
- R9: A write from source 2 is accepted only while `wireEn` is 1 and only when it targets fuse 3. Every other source-2 write is rejected.
- R10: A write from source 3 is accepted only while `hvMode` is 1. It may then write any fuse, and it clears `locked` on the same edge.
- R11: `wrErr` is 1 for exactly the one cycle that follows each rejected command and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; loads the erased fuse state |
| resetHeld | input | 1 | 1 while the device reset pin is asserted |
| hvMode | input | 1 | High-voltage programming mode is active |
| wrValid | input | 1 | Fuse write command strobe |
| wrSrc | input | 2 | Source port of the command (0 serial, 1 JTAG, 2 one-wire, 3 high-voltage) |
| wrIdx | input | 2 | Target fuse index |
| wrVal | input | 1 | Value to write into the fuse |
| serEn | output | 1 | Serial programming port enabled |
| jtagEn | output | 1 | JTAG port enabled |
| wireEn | output | 1 | One-wire debug port enabled |
| locked | output | 1 | Device locked; only the high-voltage path can recover it |
| wrErr | output | 1 | One-cycle pulse after a rejected write |
| fuses | output | 4 | Current fuse values |

## Verification
The assertions assume that `wrSrc`, `wrIdx`, `wrVal` and `hvMode` carry known values whenever `wrValid` is high. They also assume that `resetHeld` changes only between clock edges. The stimulus drives every input on the falling edge and holds it for a full cycle. Random commands draw only from the four legal source codes and the four fuse indices. High-voltage writes occur often enough to pull the bank out of locked or fully disabled states, so the protection rules keep being exercised.

// File: rtl/fusectl_pkg.sv
package fusectl_pkg;
  localparam int NUM_FUSES = 4;
  localparam int IDX_W = $clog2(NUM_FUSES);

  localparam int F_SER    = 0;
  localparam int F_PINOFF = 1;
  localparam int F_JTAG   = 2;
  localparam int F_WIRE   = 3;

  typedef enum logic [1:0] {
    SRC_SERIAL = 2'd0,
    SRC_JTAG   = 2'd1,
    SRC_WIRE   = 2'd2,
    SRC_HIGHV  = 2'd3
  } wrSrcE;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] idx;
    logic             val;
    logic             setLock;
    logic             clrLock;
    logic             reject;
  } bankCmdT;
endpackage

// File: rtl/fac_enables.sv
module fac_enables
  import fusectl_pkg::*;
(
  input  logic [NUM_FUSES-1:0] fuses,
  input  logic                 locked,
  input  logic                 resetHeld,
  output logic                 serEn,
  output logic                 jtagEn,
  output logic                 wireEn
);
  logic pinUsable;

  always_comb begin
    pinUsable = fuses[F_PINOFF] && fuses[F_WIRE];
    serEn     = !locked && resetHeld && !fuses[F_SER] && pinUsable;
    jtagEn    = !locked && !fuses[F_JTAG];
    wireEn    = !locked && !fuses[F_WIRE];
  end
endmodule

// File: rtl/fac_ctrl.sv
module fac_ctrl
  import fusectl_pkg::*;
(
  input  logic                 wrValid,
  input  logic [1:0]           wrSrc,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic                 wrVal,
  input  logic                 hvMode,
  input  logic                 serEn,
  input  logic                 jtagEn,
  input  logic                 wireEn,
  input  logic [NUM_FUSES-1:0] fuses,
  output bankCmdT              cmd
);
  wrSrcE                src;
  logic                 allowed;
  logic [NUM_FUSES-1:0] nextFuses;

  always_comb begin
    src = wrSrcE'(wrSrc);
    nextFuses = fuses;
    nextFuses[wrIdx] = wrVal;
    unique case (src)
      SRC_SERIAL: allowed = serEn && (wrIdx != IDX_W'(F_SER));
      SRC_JTAG:   allowed = jtagEn;
      SRC_WIRE:   allowed = wireEn && (wrIdx == IDX_W'(F_WIRE));
      SRC_HIGHV:  allowed = hvMode;
      default:    allowed = 1'b0;
    endcase
    cmd.wrEn    = wrValid && allowed;
    cmd.idx     = wrIdx;
    cmd.val     = wrVal;
    cmd.reject  = wrValid && !allowed;
    cmd.setLock = cmd.wrEn && (src == SRC_JTAG)
                  && nextFuses[F_SER] && nextFuses[F_JTAG];
    cmd.clrLock = cmd.wrEn && (src == SRC_HIGHV);
  end
endmodule

// File: rtl/fac_bank.sv
module fac_bank
  import fusectl_pkg::*;
#(
  parameter logic [NUM_FUSES-1:0] INIT_FUSES = '1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankCmdT              cmd,
  output logic [NUM_FUSES-1:0] fuses,
  output logic                 locked,
  output logic                 wrErr
);
  for (genvar i = 0; i < NUM_FUSES; i++) begin : g_fuse
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fuses[i] <= INIT_FUSES[i];
      end else if (cmd.wrEn && (cmd.idx == IDX_W'(i))) begin
        fuses[i] <= cmd.val;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked <= 1'b0;
      wrErr  <= 1'b0;
    end else begin
      wrErr <= cmd.reject;
      if (cmd.clrLock) begin
        locked <= 1'b0;
      end else if (cmd.setLock) begin
        locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fuse_access_ctrl.sv
module fuse_access_ctrl
  import fusectl_pkg::*;
#(
  parameter logic [NUM_FUSES-1:0] INIT_FUSES = '1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 resetHeld,
  input  logic                 hvMode,
  input  logic                 wrValid,
  input  logic [1:0]           wrSrc,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic                 wrVal,
  output logic                 serEn,
  output logic                 jtagEn,
  output logic                 wireEn,
  output logic                 locked,
  output logic                 wrErr,
  output logic [NUM_FUSES-1:0] fuses
);
  bankCmdT cmd;

  fac_ctrl ctrl_i (
    .wrValid(wrValid), .wrSrc(wrSrc), .wrIdx(wrIdx), .wrVal(wrVal),
    .hvMode(hvMode), .serEn(serEn), .jtagEn(jtagEn), .wireEn(wireEn),
    .fuses(fuses), .cmd(cmd)
  );

  fac_bank #(.INIT_FUSES(INIT_FUSES)) bank_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .fuses(fuses), .locked(locked), .wrErr(wrErr)
  );

  fac_enables en_i (
    .fuses(fuses), .locked(locked), .resetHeld(resetHeld),
    .serEn(serEn), .jtagEn(jtagEn), .wireEn(wireEn)
  );
endmodule

// File: rtl/fac_checker.sv
module fac_checker
  import fusectl_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 resetHeld,
  input logic                 hvMode,
  input logic                 wrValid,
  input logic [1:0]           wrSrc,
  input logic [IDX_W-1:0]     wrIdx,
  input logic                 wrVal,
  input logic                 serEn,
  input logic                 jtagEn,
  input logic                 wireEn,
  input logic                 locked,
  input logic                 wrErr,
  input logic [NUM_FUSES-1:0] fuses
);
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> $stable(fuses)); // R2

  AST_SER_CONDITIONS: assert property (@(posedge clk) disable iff (!rstN)
    serEn |-> (resetHeld && !fuses[F_SER] && fuses[F_PINOFF] && fuses[F_WIRE])); // R3

  AST_SER_FUSE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrSrc == 2'd0 && wrIdx == IDX_W'(F_SER))
      |=> ($stable(fuses) && wrErr)); // R5

  AST_LOCK_BLOCKS_PORTS: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (!serEn && !jtagEn && !wireEn)); // R8

  AST_WIRE_OWN_FUSE: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrSrc == 2'd2 && wrIdx != IDX_W'(F_WIRE))
      |=> ($stable(fuses) && wrErr)); // R9

  AST_HV_UNLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrSrc == 2'd3 && hvMode) |=> !locked); // R10

  AST_ERR_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> $past(wrValid)); // R11
endmodule

bind fuse_access_ctrl fac_checker chk_i (.*);

// File: tb/fuse_access_ctrl_tb.sv
module fuse_access_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       resetHeld = 1'b0;
  logic       hvMode = 1'b0;
  logic       wrValid = 1'b0;
  logic [1:0] wrSrc = 2'd0;
  logic [1:0] wrIdx = 2'd0;
  logic       wrVal = 1'b0;
  logic       serEn, jtagEn, wireEn, locked, wrErr;
  logic [3:0] fuses;

  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 0;

  logic [3:0] mFuses;
  logic       mLock;
  logic       mErr;

  always #5 clk = ~clk;

  fuse_access_ctrl dut_i (
    .clk(clk), .rstN(rstN), .resetHeld(resetHeld), .hvMode(hvMode),
    .wrValid(wrValid), .wrSrc(wrSrc), .wrIdx(wrIdx), .wrVal(wrVal),
    .serEn(serEn), .jtagEn(jtagEn), .wireEn(wireEn), .locked(locked),
    .wrErr(wrErr), .fuses(fuses)
  );

  function automatic bit expSer(logic [3:0] f, logic lk, logic rh);
    return !lk && rh && !f[0] && f[1] && f[3];
  endfunction
  function automatic bit expJtag(logic [3:0] f, logic lk);
    return !lk && !f[2];
  endfunction
  function automatic bit expWire(logic [3:0] f, logic lk);
    return !lk && !f[3];
  endfunction
  function automatic bit expAccept(logic [1:0] s, logic [1:0] i, logic hv, logic rh);
    case (s)
      2'd0: return expSer(mFuses, mLock, rh) && (i != 2'd0);
      2'd1: return expJtag(mFuses, mLock);
      2'd2: return expWire(mFuses, mLock) && (i == 2'd3);
      default: return hv;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(string tag);
    chk(tag, "fuses", fuses, mFuses);
    chk(tag, "locked", locked, mLock);
    chk(tag, "wrErr", wrErr, mErr);
    chk(tag, "serEn", serEn, expSer(mFuses, mLock, resetHeld));
    chk(tag, "jtagEn", jtagEn, expJtag(mFuses, mLock));
    chk(tag, "wireEn", wireEn, expWire(mFuses, mLock));
  endtask

  task automatic step(bit v, logic [1:0] s, logic [1:0] i, logic d,
                      logic hv, logic rh, string tag);
    bit ok;
    @(negedge clk);
    wrValid = v; wrSrc = s; wrIdx = i; wrVal = d; hvMode = hv; resetHeld = rh;
    ok = expAccept(s, i, hv, rh);
    @(posedge clk);
    mErr = v && !ok;
    if (v && ok) begin
      mFuses[i] = d;
      if (s == 2'd3) mLock = 1'b0;
      else if (s == 2'd1 && mFuses[0] && mFuses[2]) mLock = 1'b1;
    end
    #1;
    checkAll(tag);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mFuses = 4'hF; mLock = 1'b0; mErr = 1'b0;
    repeat (3) @(posedge clk);
    #1 checkAll("R1");
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1 checkAll("R1");

    step(0, 2'd0, 2'd0, 0, 0, 1, "R2");
    step(1, 2'd0, 2'd1, 0, 0, 1, "R6");
    step(1, 2'd3, 2'd0, 0, 0, 1, "R10");
    step(1, 2'd3, 2'd0, 0, 1, 1, "R10");
    step(0, 2'd0, 2'd0, 0, 0, 1, "R3");
    step(0, 2'd0, 2'd0, 0, 0, 0, "R3");
    step(1, 2'd0, 2'd2, 0, 0, 0, "R6");
    step(1, 2'd0, 2'd0, 1, 0, 1, "R5");
    step(1, 2'd0, 2'd2, 0, 0, 1, "R2");
    step(0, 2'd0, 2'd0, 0, 0, 1, "R4");
    step(1, 2'd1, 2'd0, 1, 0, 1, "R7");
    step(1, 2'd1, 2'd2, 1, 0, 1, "R8");
    step(1, 2'd0, 2'd1, 0, 0, 1, "R8");
    step(1, 2'd1, 2'd2, 0, 0, 1, "R8");
    step(1, 2'd3, 2'd2, 0, 0, 1, "R10");
    step(1, 2'd3, 2'd2, 0, 1, 1, "R10");
    step(1, 2'd2, 2'd3, 1, 0, 1, "R9");
    step(1, 2'd3, 2'd3, 0, 1, 1, "R4");
    step(1, 2'd3, 2'd0, 0, 1, 1, "R3");
    step(1, 2'd2, 2'd1, 0, 0, 1, "R9");
    step(1, 2'd2, 2'd3, 1, 0, 1, "R9");
    step(1, 2'd0, 2'd1, 0, 0, 1, "R11");
    step(1, 2'd0, 2'd1, 1, 0, 1, "R11");
    step(0, 2'd0, 2'd0, 0, 0, 1, "R11");

    for (int n = 0; n < 4000; n++) begin
      bit v = ($urandom_range(0, 9) < 7);
      logic [1:0] s = 2'($urandom_range(0, 3));
      logic [1:0] i = 2'($urandom_range(0, 3));
      logic d = 1'($urandom_range(0, 1));
      logic hv = ($urandom_range(0, 3) == 0);
      logic rh = ($urandom_range(0, 9) < 7);
      step(v, s, i, d, hv, rh, "R2 R7 R8 R11");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule